// File: doc/BRIEF.md
# RTC Register Write-Protection and Init-Mode Controller

This block stands in front of the configuration registers of a real-time clock. Software reaches it through single-cycle register writes: an address, a data word and a write strobe. Every register except the key register is guarded. Writes to the guarded registers take effect only after a two-byte unlock sequence has been written to the key register. Any later write to the key register locks the guard again.

Loading the calendar follows a handshake. With the guard open, software sets the init-request bit in the control register. The block then raises a freeze signal that stops the calendar counters. After a fixed, parameterized latency it raises an init-ready flag. While that flag is high, writes to the time and date registers are passed to the calendar as a one-cycle write strobe carrying the data. The hour-format bit and the prescaler value are held outside the block's init mode and can change only inside it. Clearing the init-request bit releases the counters, which then run on from the newly loaded values.

The write interface is plain single-cycle control with no back-pressure. A write is consumed in the cycle its strobe is high and cannot be stalled, so the interface needs no valid/ready pair.

Top module: `rtc_wprot_ctrl`

## Requirements
- R1: After reset, unlocked_o, freeze_o, init_ready_o, fmt_12h_o and cal_we_o are 0, and presc_o equals the PRESC_RST parameter.
- R2: A write of 0xCA to the key address (0), followed by a write of 0x53 to that address, sets unlocked_o from the clock edge that takes the second write. Only data bits [7:0] are compared. Writes to other addresses between the two key writes do not break the sequence.
- R3: A first key write other than 0xCA leaves the block locked. A second key write other than 0x53 returns the block to locked. After that, the whole sequence must start again from 0xCA.
- R4: While the block is unlocked, any write to the key address, for example 0xFF, clears unlocked_o at the edge that takes the write.
- R5: While the block is locked, writes to the control address (1), prescaler address (2), time address (3) or date address (4) are ignored. freeze_o, fmt_12h_o and presc_o keep their values, and cal_we_o stays 0.
- R6: An unlocked write to the control address sets freeze_o to data bit 0 at the edge that takes the write. When freeze_o falls, init_ready_o falls in the same cycle.
- R7: init_ready_o rises exactly READY_LAT clock cycles after freeze_o rises, and stays high while freeze_o stays high.
- R8: fmt_12h_o takes control data bit 1, and presc_o takes the prescaler write data, only when the write arrives while the block is unlocked and freeze_o is already 1. Otherwise both keep their values.
- R9: An unlocked write to the time or date address while init_ready_o is 1 makes cal_we_o high for exactly the next cycle. In that cycle cal_sel_o is 0 for time and 1 for date, and cal_data_o holds the write data. In any other case cal_we_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | 3 | Register address (0 key, 1 control, 2 prescaler, 3 time, 4 date) |
| wr_data_i | input | DATA_W | Write data |
| unlocked_o | output | 1 | Guard open: guarded writes are accepted |
| freeze_o | output | 1 | Init mode: calendar counters stopped |
| init_ready_o | output | 1 | Calendar registers may be loaded |
| fmt_12h_o | output | 1 | Hour format, 1 = 12-hour, 0 = 24-hour |
| presc_o | output | PRESC_W | Prescaler value |
| cal_we_o | output | 1 | Write strobe to the calendar registers |
| cal_sel_o | output | 1 | Calendar target, 0 = time, 1 = date |
| cal_data_o | output | DATA_W | Data for the calendar write |

## Verification
The assertions assume that wr_addr_i and wr_data_i are known whenever wr_en_i is high. They also assume READY_LAT is at least one, so that a rise of init_ready_o always follows a cycle in which freeze_o was already high. The bench changes its inputs only on falling edges and drops the strobe between writes. It sweeps all 256 first-key and all 256 second-key byte values against a small latency, and samples every registered output on the falling edge after the edge that took the write.

// File: rtl/rtc_wp_pkg.sv
package rtc_wp_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_KEY   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd2;
  localparam logic [ADDR_W-1:0] A_TIME  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int CTRL_INIT_BIT = 0;
  localparam int CTRL_FMT_BIT  = 1;

  typedef enum logic [1:0] {
    GUARD_LOCKED = 2'd0,
    GUARD_HALF   = 2'd1,
    GUARD_OPEN   = 2'd2
  } guard_state_e;
endpackage

// File: rtl/rtc_wp_keyfsm.sv
module rtc_wp_keyfsm
  import rtc_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  output logic       unlocked_o
);
  guard_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      unique case (st_q)
        GUARD_LOCKED: st_d = (key_i == KEY_FIRST)  ? GUARD_HALF : GUARD_LOCKED;
        GUARD_HALF:   st_d = (key_i == KEY_SECOND) ? GUARD_OPEN : GUARD_LOCKED;
        GUARD_OPEN:   st_d = GUARD_LOCKED;
        default:      st_d = GUARD_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GUARD_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked_o = (st_q == GUARD_OPEN);
endmodule

// File: rtl/rtc_wp_initctl.sv
module rtc_wp_initctl #(
  parameter int READY_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_i,
  input  logic req_i,
  output logic freeze_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(READY_LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(READY_LAT - 1);

  logic             req_q;
  logic             rdy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (ctrl_wr_i) req_q <= req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!req_q) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      cnt_q <= cnt_q + 1'b1;
      rdy_q <= (cnt_q == LAST);
    end
  end

  assign freeze_o = req_q;
  assign ready_o  = rdy_q & req_q;
endmodule

// File: rtl/rtc_wp_cfgregs.sv
module rtc_wp_cfgregs #(
  parameter int              PRESC_W   = 23,
  parameter logic [PRESC_W-1:0] PRESC_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fmt_we_i,
  input  logic               fmt_d_i,
  input  logic               presc_we_i,
  input  logic [PRESC_W-1:0] presc_d_i,
  output logic               fmt_o,
  output logic [PRESC_W-1:0] presc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_o <= 1'b0;
    else if (fmt_we_i) fmt_o <= fmt_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_o <= PRESC_RST;
    else if (presc_we_i) presc_o <= presc_d_i;
  end
endmodule

// File: rtl/rtc_wp_calgate.sv
module rtc_wp_calgate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              time_wr_i,
  input  logic              date_wr_i,
  input  logic              allow_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic              sel_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit;
  assign hit = allow_i & (time_wr_i | date_wr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o   <= 1'b0;
      sel_o  <= 1'b0;
      data_o <= '0;
    end else begin
      we_o <= hit;
      if (hit) begin
        sel_o  <= date_wr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/rtc_wprot_ctrl.sv
module rtc_wprot_ctrl
  import rtc_wp_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 PRESC_W   = 23,
  parameter logic [PRESC_W-1:0] PRESC_RST = 23'h7F00FF,
  parameter int                 READY_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               unlocked_o,
  output logic               freeze_o,
  output logic               init_ready_o,
  output logic               fmt_12h_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               cal_we_o,
  output logic               cal_sel_o,
  output logic [DATA_W-1:0]  cal_data_o
);
  logic key_wr, ctrl_wr, presc_wr, time_wr, date_wr;

  assign key_wr   = wr_en_i && (wr_addr_i == A_KEY);
  assign ctrl_wr  = wr_en_i && (wr_addr_i == A_CTRL)  && unlocked_o;
  assign presc_wr = wr_en_i && (wr_addr_i == A_PRESC) && unlocked_o;
  assign time_wr  = wr_en_i && (wr_addr_i == A_TIME)  && unlocked_o;
  assign date_wr  = wr_en_i && (wr_addr_i == A_DATE)  && unlocked_o;

  rtc_wp_keyfsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr_i   (key_wr),
    .key_i      (wr_data_i[7:0]),
    .unlocked_o (unlocked_o)
  );

  rtc_wp_initctl #(.READY_LAT(READY_LAT)) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr_i (ctrl_wr),
    .req_i     (wr_data_i[CTRL_INIT_BIT]),
    .freeze_o  (freeze_o),
    .ready_o   (init_ready_o)
  );

  rtc_wp_cfgregs #(.PRESC_W(PRESC_W), .PRESC_RST(PRESC_RST)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_we_i   (ctrl_wr && freeze_o),
    .fmt_d_i    (wr_data_i[CTRL_FMT_BIT]),
    .presc_we_i (presc_wr && freeze_o),
    .presc_d_i  (wr_data_i[PRESC_W-1:0]),
    .fmt_o      (fmt_12h_o),
    .presc_o    (presc_o)
  );

  rtc_wp_calgate #(.DATA_W(DATA_W)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_wr_i (time_wr),
    .date_wr_i (date_wr),
    .allow_i   (init_ready_o),
    .data_i    (wr_data_i),
    .we_o      (cal_we_o),
    .sel_o     (cal_sel_o),
    .data_o    (cal_data_o)
  );
endmodule

// File: rtl/rtc_wprot_ctrl_chk.sv
module rtc_wprot_ctrl_chk
  import rtc_wp_pkg::*;
#(
  parameter int PRESC_W = 23
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [7:0]         key_byte,
  input logic               unlocked_o,
  input logic               freeze_o,
  input logic               init_ready_o,
  input logic               fmt_12h_o,
  input logic [PRESC_W-1:0] presc_o,
  input logic               cal_we_o
);
  AST_UNLOCK_NEEDS_KEY2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(wr_en_i && wr_addr_i == A_KEY && key_byte == KEY_SECOND)); // R2
  AST_KEY_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_o && wr_en_i && wr_addr_i == A_KEY) |=> !unlocked_o); // R4
  AST_PRESC_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unlocked_o) |-> $stable(presc_o)); // R5
  AST_FREEZE_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unlocked_o) |-> $stable(freeze_o)); // R5
  AST_READY_IMPLIES_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready_o |-> freeze_o); // R6
  AST_READY_AFTER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ready_o) |-> $past(freeze_o)); // R7
  AST_FMT_HELD_OUTSIDE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(freeze_o) |-> $stable(fmt_12h_o)); // R8
  AST_CALWE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we_o |-> $past(unlocked_o && init_ready_o)); // R9
endmodule

bind rtc_wprot_ctrl rtc_wprot_ctrl_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .key_byte     (wr_data_i[7:0]),
  .unlocked_o   (unlocked_o),
  .freeze_o     (freeze_o),
  .init_ready_o (init_ready_o),
  .fmt_12h_o    (fmt_12h_o),
  .presc_o      (presc_o),
  .cal_we_o     (cal_we_o)
);

// File: tb/rtc_wprot_ctrl_bench.sv
module rtc_wprot_ctrl_bench;
  localparam int DATA_W = 32;
  localparam int PRESC_W = 23;
  localparam logic [PRESC_W-1:0] PRST = 23'h7F00FF;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic unlocked, freeze, ready, fmt, cal_we, cal_sel;
  logic [PRESC_W-1:0] presc;
  logic [DATA_W-1:0] cal_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rtc_wprot_ctrl #(.DATA_W(DATA_W), .PRESC_W(PRESC_W), .PRESC_RST(PRST), .READY_LAT(LAT)) u_rtc_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .unlocked_o(unlocked), .freeze_o(freeze), .init_ready_o(ready), .fmt_12h_o(fmt),
    .presc_o(presc), .cal_we_o(cal_we), .cal_sel_o(cal_sel), .cal_data_o(cal_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd0, 32'hCA);
    wr(3'd0, 32'h53);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 unlocked", unlocked, 0);
    chk("R1 freeze", freeze, 0);
    chk("R1 ready", ready, 0);
    chk("R1 fmt", fmt, 0);
    chk("R1 presc", presc, PRST);
    chk("R1 cal_we", cal_we, 0);

    // R3 sweep of first key; upper data bits set to show only [7:0] counts (R2)
    for (int k = 0; k < 256; k++) begin
      wr(3'd0, {24'hABCDEF, 8'(k)});
      wr(3'd0, 32'h53);
      chk(k == 8'hCA ? "R2 first key" : "R3 first key", unlocked, (k == 8'hCA));
      if (unlocked) wr(3'd0, 32'hFF);
      chk("R4 relock", unlocked, 0);
    end

    // R3 sweep of second key, then show that a fresh 0x53 does not unlock
    for (int k = 0; k < 256; k++) begin
      wr(3'd0, 32'hCA);
      wr(3'd0, {24'h123456, 8'(k)});
      chk(k == 8'h53 ? "R2 second key" : "R3 second key", unlocked, (k == 8'h53));
      if (unlocked) wr(3'd0, 32'h00);
      else begin
        wr(3'd0, 32'h53);
        chk("R3 restart needed", unlocked, 0);
      end
    end

    // R2 non-key write between keys keeps the sequence
    wr(3'd0, 32'hCA);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h53);
    chk("R2 interleaved", unlocked, 1);
    wr(3'd0, 32'hFF);

    // R5 locked writes ignored
    wr(3'd1, 32'h3);
    chk("R5 ctrl locked", freeze, 0);
    chk("R5 fmt locked", fmt, 0);
    wr(3'd2, 32'h1234);
    chk("R5 presc locked", presc, PRST);
    wr(3'd3, 32'h55);
    chk("R5 time locked", cal_we, 0);

    // R8 fmt/presc outside init ignored even when unlocked
    unlock();
    wr(3'd2, 32'h2222);
    chk("R8 presc no init", presc, PRST);
    wr(3'd1, 32'h2);
    chk("R8 fmt no init", fmt, 0);
    chk("R6 freeze bit0 clear", freeze, 0);

    // R9 calendar write before init ready is blocked
    wr(3'd3, 32'h77);
    chk("R9 no ready", cal_we, 0);

    // R6/R7 init handshake timing
    wr(3'd1, 32'h1);
    chk("R6 freeze set", freeze, 1);
    chk("R7 ready t0", ready, 0);
    for (int i = 1; i <= LAT + 2; i++) begin
      @(negedge clk);
      chk("R7 ready timing", ready, (i >= LAT));
    end

    // R8 changes allowed in init mode
    wr(3'd1, 32'h3);
    chk("R8 fmt in init", fmt, 1);
    chk("R6 stays frozen", freeze, 1);
    wr(3'd2, 32'h00ABCD);
    chk("R8 presc in init", presc, 23'h00ABCD);

    // R9 time and date pulses
    wr(3'd3, 32'h00123456);
    chk("R9 time we", cal_we, 1);
    chk("R9 time sel", cal_sel, 0);
    chk("R9 time data", cal_data, 32'h00123456);
    @(negedge clk);
    chk("R9 one cycle", cal_we, 0);
    wr(3'd4, 32'h00250301);
    chk("R9 date we", cal_we, 1);
    chk("R9 date sel", cal_sel, 1);
    chk("R9 date data", cal_data, 32'h00250301);

    // R5 relock inside init: calendar writes and exit blocked
    wr(3'd0, 32'hFF);
    wr(3'd4, 32'h9);
    chk("R5 date locked", cal_we, 0);
    wr(3'd1, 32'h0);
    chk("R5 exit locked", freeze, 1);

    // R6 exit init
    unlock();
    wr(3'd1, 32'h2);
    chk("R6 freeze clear", freeze, 0);
    chk("R6 ready falls", ready, 0);
    chk("R8 fmt kept", fmt, 1);
    chk("R8 presc kept", presc, 23'h00ABCD);

    // R1 reset mid-operation
    wr(3'd1, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset lock", unlocked, 0);
    chk("R1 re-reset freeze", freeze, 0);
    chk("R1 re-reset presc", presc, PRST);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule